// File: doc/BRIEF.md
# Dynamic Bus Sizing Unit

This block connects a CPU-side request port, which moves either a byte or a 16-bit word per request, to an external bus whose 24-bit address lines and 16-bit data lines are separate. While a bus cycle runs, the external address decoder reports whether the addressed target is 8 bits wide. The unit reads that report in the first clock of every cycle. It chooses the byte lanes from it, and it breaks a transfer into two byte cycles whenever one cycle cannot carry it. Read bytes from the two cycles are merged into one word. The CPU side sees a single completion for each request.

The same logic serves 16-bit and 8-bit targets. A word access to a narrow target, or to an odd address, becomes two cycles: the first cycle moves the low byte at the requested address, and the second moves the high byte at the next address on lanes [7:0]. A bus cycle has one address clock (T1), then one or more data clocks (T2). The cycle ends at the rising edge where the ready input is high during a T2 clock. Wait states therefore come from outside.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_busy`, `req_done` and `ext_doe` are 0, `ext_rd_n` and `ext_wr_n` are 1, and `ext_be_n` is 2'b11.
- R2: A request is taken at a rising edge where `req_valid` is 1 and `req_busy` is 0. `req_busy` stays 1 until the request completes. Completion is a single-clock `req_done` pulse, with `req_busy` already 0 in that clock.
- R3: Every bus cycle has exactly one clock with `ext_astb` high (T1), followed by T2 clocks. The cycle ends at the first rising edge in T2 where `ext_ready` is 1, so a cycle with N wait clocks has N+1 T2 clocks and lasts at least two clocks. `ext_addr` is constant throughout the cycle, and only one of `ext_rd_n` or `ext_wr_n` is low at any time.
- R4: A word request to an even address on a 16-bit target (`ext_narrow` 0 in T1) uses one cycle with `ext_be_n` = 2'b00 and moves the whole word. The low byte is on bits [7:0].
- R5: On a 16-bit target, a byte request moves on lane [15:8] (`ext_be_n` = 2'b01) for an odd address and on lane [7:0] (`ext_be_n` = 2'b10) for an even one. Byte reads return the byte in `req_rdata[7:0]` with `req_rdata[15:8]` = 0.
- R6: `ext_narrow` is sampled in T1. When it is 1, `ext_be_n` is 2'b10 during T2 and the byte is taken from, or placed on, bits [7:0], whatever the address parity.
- R7: A word request to an even address that meets `ext_narrow` = 1 becomes two cycles at address A and A+1, both on lanes [7:0]. The read result is {second byte, first byte}, and there is only one `req_done`.
- R8: A word request to an odd address always becomes two cycles: the low byte at A (lane chosen as in R5/R6), then the high byte at A+1 with `ext_be_n` = 2'b10 in T2.
- R9: For writes, `ext_doe` is 1 for the whole of each cycle and is 0 for reads. A byte write, including the high-byte cycle of a split word, drives the byte on both lanes. A single-cycle word write drives the word unchanged. After a write, a read of the same location returns the written data.
- R10: The address of a second cycle is A+1 modulo 2^24, so 24'hFFFFFF is followed by 24'h000000.
- R11: A `req_valid` that arrives while `req_busy` is 1 is ignored. It starts no cycle and produces no extra `req_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 24 | Byte address of the request |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result, valid with `req_done` and held after it |
| ext_addr | output | 24 | External byte address |
| ext_astb | output | 1 | High in the first clock (T1) of each bus cycle |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_be_n | output | 2 | Lane enables, active low; bit 0 = lane [7:0], bit 1 = lane [15:8] |
| ext_dout | output | 16 | Write data towards the bus |
| ext_doe | output | 1 | Drive enable for `ext_dout` |
| ext_din | input | 16 | Read data from the bus |
| ext_narrow | input | 1 | Decoder report in T1: target is 8 bits wide |
| ext_ready | input | 1 | Ends the cycle when high in a T2 clock |

## Verification
The assertions assume that `ext_narrow` is valid in every T1 clock and that `ext_ready` is meaningful only in T2. They also assume that requests are offered only through the valid/busy handshake. The bench target model follows these rules. It derives `ext_narrow` in T1 from address bit 23, so the upper half of the space acts as an 8-bit target. It holds `ext_ready` low for a chosen number of T2 clocks, and it puts a marker byte on the unused upper lane of a narrow target, so a wrong lane choice shows up in the data. Requests are issued only when `req_busy` is low, except for one deliberate burst of `req_valid` during a busy period.

// File: rtl/bsz_pkg.sv
// Package: shared types and constants for the dynamic bus sizing unit.
// Assumes a bus made of exactly two byte lanes.
package bsz_pkg;

    localparam int NLANE = 2;

    // Bus cycle phase: idle, address clock, data clock(s).
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2
    } bsz_state_e;

    // Lane enable codes, active low, bit 0 = lane [7:0].
    localparam logic [NLANE-1:0] BE_BOTH = 2'b00;
    localparam logic [NLANE-1:0] BE_HIGH = 2'b01;
    localparam logic [NLANE-1:0] BE_LOW  = 2'b10;
    localparam logic [NLANE-1:0] BE_NONE = 2'b11;

endpackage

// File: rtl/bsz_seq.sv
// Module: bsz_seq
// Cycle sequencer. It takes a request when idle, runs one or two bus
// cycles (T1 then T2 until ready) and decides after the first cycle
// whether a second, high-byte cycle at address+1 is needed. It samples the
// narrow-target report in T1 and emits a registered completion pulse.
// Assumes ext_narrow is valid in T1 and ext_ready is meaningful in T2.
module bsz_seq
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ext_narrow,
    input  logic              ext_ready,
    output bsz_state_e        state,
    output logic              part,
    output logic              narrow_q,
    output logic              write_q,
    output logic              word_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              accept,
    output logic              cyc_end,
    output logic              done
);

    logic [ADDR_W-1:0] base_q;
    logic              need_second;

    // Request taken only while idle.
    always_comb accept = req_valid && (state == ST_IDLE);

    // A bus cycle ends at a T2 edge with ready high.
    always_comb cyc_end = (state == ST_T2) && ext_ready;

    // A second cycle follows a word's first cycle if odd or narrow.
    always_comb need_second = word_q && !part && (base_q[0] || narrow_q);

    // Address of the running cycle: base, or base+1 for the high byte.
    always_comb cur_addr = part ? base_q + ADDR_W'(1) : base_q;

    // Phase register: idle -> T1 -> T2 (held until ready).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_T1;
                ST_T1:   state <= ST_T2;
                ST_T2:   if (ext_ready) state <= need_second ? ST_T1 : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request attributes latched on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            write_q <= 1'b0;
            word_q  <= 1'b0;
        end else if (accept) begin
            base_q  <= req_addr;
            write_q <= req_write;
            word_q  <= req_word;
        end
    end

    // Which half of the request the current cycle moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= 1'b0;
        end else if (accept) begin
            part <= 1'b0;
        end else if (cyc_end && need_second) begin
            part <= 1'b1;
        end
    end

    // Narrow-target report captured in the address clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow_q <= 1'b0;
        end else if (state == ST_T1) begin
            narrow_q <= ext_narrow;
        end
    end

    // One-clock completion pulse after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= cyc_end && !need_second;
        end
    end

endmodule

// File: rtl/bsz_lane.sv
// Module: bsz_lane
// Lane steering for writes and lane enables. It holds the write word,
// builds the active-low lane enables (wide guess in T1, narrow-corrected
// in T2) and places write bytes on the lanes. A byte is replicated on both
// lanes so that it is on lane [7:0] whichever width the target reports.
// Assumes a two-lane bus.
module bsz_lane
    import bsz_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [NLANE*LANE_W-1:0] req_wdata,
    input  logic                    active,
    input  logic                    in_t2,
    input  logic                    word_q,
    input  logic                    part,
    input  logic                    addr0,
    input  logic                    narrow_q,
    output logic [NLANE-1:0]        be_n,
    output logic [NLANE*LANE_W-1:0] dout
);

    localparam int DATA_W = NLANE * LANE_W;

    logic [DATA_W-1:0] wdata_q;
    logic              full;
    logic [NLANE-1:0]  wide_be;
    logic [LANE_W-1:0] byte_sel;

    // Write word held for the whole request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (accept) begin
            wdata_q <= req_wdata;
        end
    end

    // Cycle may carry the whole word (even word, first half).
    always_comb full = word_q && !part && !addr0;

    // Lane enables assuming a 16-bit target.
    always_comb begin
        if (full)       wide_be = BE_BOTH;
        else if (addr0) wide_be = BE_HIGH;
        else            wide_be = BE_LOW;
    end

    // Final enables: none idle, lower lane once a narrow target is known.
    always_comb begin
        if (!active)                be_n = BE_NONE;
        else if (in_t2 && narrow_q) be_n = BE_LOW;
        else                        be_n = wide_be;
    end

    // Byte moved by a byte cycle: upper byte in the second half.
    always_comb byte_sel = part ? wdata_q[LANE_W +: LANE_W] : wdata_q[0 +: LANE_W];

    // Per-lane write data: word lanes when full, else the byte everywhere.
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = full ? wdata_q[i*LANE_W +: LANE_W] : byte_sel;
    end

endmodule

// File: rtl/bsz_gather.sv
// Module: bsz_gather
// Read data assembly. At the end of each read cycle it takes either the
// full bus word (wide, even, first half) or one byte from the lane the
// cycle used, and stores it in the low or high half of the result. It
// clears the result when a request is taken, so byte reads return zero in
// the upper half. Assumes a two-lane bus.
module bsz_gather
    import bsz_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    cyc_end,
    input  logic                    write_q,
    input  logic                    word_q,
    input  logic                    part,
    input  logic                    addr0,
    input  logic                    narrow_q,
    input  logic [NLANE*LANE_W-1:0] din,
    output logic [NLANE*LANE_W-1:0] rdata
);

    logic [LANE_W-1:0] lo_q;
    logic [LANE_W-1:0] hi_q;
    logic [LANE_W-1:0] pick;
    logic              take_word;

    // Whole word arrives in one wide cycle.
    always_comb take_word = word_q && !part && !addr0 && !narrow_q;

    // Byte lane used: upper only for an odd address on a wide target.
    always_comb pick = (!narrow_q && addr0) ? din[LANE_W +: LANE_W] : din[0 +: LANE_W];

    // Result halves: cleared on acceptance, filled at read cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cyc_end && !write_q) begin
            if (take_word) begin
                lo_q <= din[0 +: LANE_W];
                hi_q <= din[LANE_W +: LANE_W];
            end else if (part) begin
                hi_q <= pick;
            end else begin
                lo_q <= pick;
            end
        end
    end

    // Assembled result towards the CPU side.
    always_comb rdata = {hi_q, lo_q};

endmodule

// File: rtl/dyn_bus_sizer.sv
// Module: dyn_bus_sizer
// Top of the dynamic bus sizing unit. It connects the sequencer, the lane
// steering and the read assembly, and drives the strobes. Each request
// becomes one or two external cycles, depending on address parity and on
// the per-cycle narrow-target report. Assumes wait states come from outside
// through ext_ready.
module dyn_bus_sizer
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_word,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [NLANE*LANE_W-1:0] req_wdata,
    output logic                    req_busy,
    output logic                    req_done,
    output logic [NLANE*LANE_W-1:0] req_rdata,
    output logic [ADDR_W-1:0]       ext_addr,
    output logic                    ext_astb,
    output logic                    ext_rd_n,
    output logic                    ext_wr_n,
    output logic [NLANE-1:0]        ext_be_n,
    output logic [NLANE*LANE_W-1:0] ext_dout,
    output logic                    ext_doe,
    input  logic [NLANE*LANE_W-1:0] ext_din,
    input  logic                    ext_narrow,
    input  logic                    ext_ready
);

    bsz_state_e        state;
    logic              part;
    logic              narrow_q;
    logic              write_q;
    logic              word_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              accept;
    logic              cyc_end;
    logic              active;
    logic              in_t2;

    bsz_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .ext_narrow (ext_narrow),
        .ext_ready  (ext_ready),
        .state      (state),
        .part       (part),
        .narrow_q   (narrow_q),
        .write_q    (write_q),
        .word_q     (word_q),
        .cur_addr   (cur_addr),
        .accept     (accept),
        .cyc_end    (cyc_end),
        .done       (req_done)
    );

    // Phase decodes shared by the strobes and the lane logic.
    always_comb begin
        active = (state != ST_IDLE);
        in_t2  = (state == ST_T2);
    end

    bsz_lane #(.LANE_W(LANE_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .active    (active),
        .in_t2     (in_t2),
        .word_q    (word_q),
        .part      (part),
        .addr0     (cur_addr[0]),
        .narrow_q  (narrow_q),
        .be_n      (ext_be_n),
        .dout      (ext_dout)
    );

    bsz_gather #(.LANE_W(LANE_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cyc_end  (cyc_end),
        .write_q  (write_q),
        .word_q   (word_q),
        .part     (part),
        .addr0    (cur_addr[0]),
        .narrow_q (narrow_q),
        .din      (ext_din),
        .rdata    (req_rdata)
    );

    // Bus strobes and handshake outputs.
    always_comb begin
        req_busy = active;
        ext_addr = cur_addr;
        ext_astb = (state == ST_T1);
        ext_rd_n = !(active && !write_q);
        ext_wr_n = !(active && write_q);
        ext_doe  = active && write_q;
    end

endmodule

// File: rtl/bsz_chk.sv
// Module: bsz_chk
// Property checker for dyn_bus_sizer, attached with bind. It only observes
// the top-level ports.
module bsz_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_busy,
    input logic              req_done,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_astb,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic [1:0]        ext_be_n,
    input logic              ext_doe,
    input logic              ext_narrow
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (ext_rd_n && ext_wr_n && !ext_doe && ext_be_n == 2'b11));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !req_busy);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    p_t1_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_astb |=> !ext_astb);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_busy && !ext_astb) |-> $stable(ext_addr));

    p_lane_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_busy |-> ext_be_n != 2'b11);

    p_narrow_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_astb && ext_narrow) |=> ext_be_n == 2'b10);

    p_next_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_astb && $past(req_busy)) |-> ext_addr == ADDR_W'($past(ext_addr) + 1'b1));

endmodule

bind dyn_bus_sizer bsz_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_busy   (req_busy),
    .req_done   (req_done),
    .ext_addr   (ext_addr),
    .ext_astb   (ext_astb),
    .ext_rd_n   (ext_rd_n),
    .ext_wr_n   (ext_wr_n),
    .ext_be_n   (ext_be_n),
    .ext_doe    (ext_doe),
    .ext_narrow (ext_narrow)
);

// File: tb/dyn_bus_sizer_tb.sv
`timescale 1ns/1ps
module dyn_bus_sizer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_busy;
    logic        req_done;
    logic [15:0] req_rdata;
    logic [23:0] ext_addr;
    logic        ext_astb;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [1:0]  ext_be_n;
    logic [15:0] ext_dout;
    logic        ext_doe;
    logic [15:0] ext_din = '0;
    logic        ext_narrow = 1'b0;
    logic        ext_ready = 1'b0;

    always #4 clk = ~clk;

    dyn_bus_sizer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
        .ext_addr(ext_addr), .ext_astb(ext_astb), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_be_n(ext_be_n), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din), .ext_narrow(ext_narrow),
        .ext_ready(ext_ready)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte memories: target model and independent reference.
    logic [7:0] tmem [int];
    logic [7:0] rmem [int];

    function automatic logic [7:0] seed(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] tget(input logic [23:0] a);
        return tmem.exists(int'(a)) ? tmem[int'(a)] : seed(a);
    endfunction
    function automatic logic [7:0] rget(input logic [23:0] a);
        return rmem.exists(int'(a)) ? rmem[int'(a)] : seed(a);
    endfunction

    // Target model: narrow when address bit 23 is set, programmable waits.
    int          wait_n = 0;
    int          cnt = 0;
    int          t2n = 0;
    bit          cyc_narrow = 0;
    logic [23:0] cyc_addr = '0;
    logic [23:0] q_addr [$];
    logic [1:0]  q_be [$];
    int          q_t2 [$];
    logic        q_doe [$];

    always @(negedge clk) begin
        if (ext_astb) begin
            cyc_addr   = ext_addr;
            cyc_narrow = ext_addr[23];
            ext_narrow <= ext_addr[23];
            cnt        = wait_n;
            t2n        = 0;
            ext_ready  <= 1'b0;
            q_addr.push_back(ext_addr);
        end else if (!ext_rd_n || !ext_wr_n) begin
            t2n++;
            if (cyc_narrow)
                ext_din <= {8'hEE, tget(cyc_addr)};
            else
                ext_din <= {tget(cyc_addr | 24'h1), tget(cyc_addr & 24'hFFFFFE)};
            if (cnt == 0) begin
                ext_ready <= 1'b1;
                q_be.push_back(ext_be_n);
                q_t2.push_back(t2n);
                q_doe.push_back(ext_doe);
                if (!ext_wr_n) begin
                    if (cyc_narrow) begin
                        if (!ext_be_n[0]) tmem[int'(cyc_addr)] = ext_dout[7:0];
                    end else begin
                        if (!ext_be_n[0]) tmem[int'(cyc_addr & 24'hFFFFFE)] = ext_dout[7:0];
                        if (!ext_be_n[1]) tmem[int'(cyc_addr | 24'h1)] = ext_dout[15:8];
                    end
                end
            end else begin
                ext_ready <= 1'b0;
                cnt--;
            end
        end else begin
            ext_ready <= 1'b0;
        end
    end

    // Scoreboard: driver pushes, monitor pops on each completion.
    typedef struct {
        bit          rd;
        logic [15:0] exp;
        string       req;
    } sb_item_t;
    sb_item_t sbq [$];
    int done_seen = 0;

    always @(negedge clk) begin
        if (rst_n && req_done) begin
            done_seen++;
            if (sbq.size() == 0) begin
                chk(0, "R2", "unexpected completion", 32'd1, 32'd0);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (it.rd) chk(req_rdata == it.exp, it.req, "read data", req_rdata, it.exp);
            end
        end
    end

    // Driver: one request, expected data into the scoreboard, cycle log checks.
    task automatic do_req(input bit wr, input bit word, input logic [23:0] a,
                          input logic [15:0] wd, input int waits,
                          input string req, input bit poke);
        sb_item_t    it;
        logic [23:0] a2;
        bit          nar;
        int          ncyc;
        int          target;
        logic [1:0]  be1;
        a2  = a + 24'd1;
        nar = a[23];
        ncyc = (word && (a[0] || nar)) ? 2 : 1;
        be1 = nar ? 2'b10 : ((word && !a[0]) ? 2'b00 : (a[0] ? 2'b01 : 2'b10));
        while (req_busy) @(negedge clk);
        q_addr.delete(); q_be.delete(); q_t2.delete(); q_doe.delete();
        wait_n = waits;
        it.rd  = !wr;
        it.req = req;
        it.exp = word ? {rget(a2), rget(a)} : {8'h00, rget(a)};
        if (wr) begin
            rmem[int'(a)] = wd[7:0];
            if (word) rmem[int'(a2)] = wd[15:8];
        end
        sbq.push_back(it);
        target = done_seen + 1;
        req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_addr = a ^ 24'h000055;
            req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_seen < target) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(done_seen == target, req, "completions", done_seen, target);
        chk(q_addr.size() == ncyc, req, "cycle count", q_addr.size(), ncyc);
        if (q_addr.size() >= 1 && q_be.size() >= 1) begin
            chk(q_addr[0] == a, req, "first address", q_addr[0], a);
            chk(q_be[0] == be1, req, "first lane enables", q_be[0], be1);
            chk(q_t2[0] == waits + 1, "R3", "T2 clocks", q_t2[0], waits + 1);
            chk(q_doe[0] == wr, "R9", "drive enable", q_doe[0], wr);
        end
        if (ncyc == 2 && q_addr.size() >= 2 && q_be.size() >= 2) begin
            chk(q_addr[1] == a2, req, "second address", q_addr[1], a2);
            chk(q_be[1] == 2'b10, req, "second lane enables", q_be[1], 2'b10);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!req_busy && !req_done && !ext_doe, "R1", "busy/done/doe", {req_busy, req_done, ext_doe}, 0);
        chk(ext_rd_n && ext_wr_n, "R1", "strobes", {ext_rd_n, ext_wr_n}, 2'b11);
        chk(ext_be_n == 2'b11, "R1", "lane enables", ext_be_n, 2'b11);

        do_req(0, 1, 24'h000010, 16'h0, 0, "R4", 0);
        do_req(0, 1, 24'h000020, 16'h0, 3, "R3", 0);
        do_req(0, 0, 24'h000031, 16'h0, 1, "R5", 0);
        do_req(0, 0, 24'h000032, 16'h0, 0, "R5", 0);
        do_req(0, 1, 24'h800010, 16'h0, 0, "R7", 0);
        do_req(0, 1, 24'h800042, 16'h0, 2, "R6", 0);
        do_req(0, 0, 24'h800051, 16'h0, 0, "R6", 0);
        do_req(0, 1, 24'h000061, 16'h0, 1, "R8", 0);
        do_req(0, 1, 24'h800071, 16'h0, 0, "R8", 0);
        do_req(0, 1, 24'hFFFFFF, 16'h0, 0, "R10", 0);

        // R9: writes of each shape, then read back
        do_req(1, 1, 24'h000100, 16'hA1B2, 0, "R9", 0);
        do_req(1, 1, 24'h800200, 16'hC3D4, 1, "R9", 0);
        do_req(1, 0, 24'h800301, 16'h00E5, 0, "R9", 0);
        do_req(1, 0, 24'h000401, 16'h00F6, 0, "R9", 0);
        do_req(1, 1, 24'h000503, 16'h1728, 0, "R9", 0);
        do_req(0, 1, 24'h000100, 16'h0, 0, "R9", 0);
        do_req(0, 1, 24'h800200, 16'h0, 0, "R9", 0);
        do_req(0, 0, 24'h800301, 16'h0, 0, "R9", 0);
        do_req(0, 0, 24'h000401, 16'h0, 0, "R9", 0);
        do_req(0, 1, 24'h000503, 16'h0, 0, "R9", 0);

        // R11: requests offered while busy are ignored
        do_req(0, 1, 24'h000611, 16'h0, 2, "R11", 1);

        // Mixed traffic over a small pool (R2 handshake under load)
        for (int i = 0; i < 60; i++) begin
            logic [23:0] ra;
            ra = {($urandom % 2 == 1), 15'd0, 8'($urandom % 24)};
            do_req($urandom % 2 == 1, $urandom % 2 == 1, ra, 16'($urandom),
                   int'($urandom % 3), "R2", 0);
        end
        chk(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule